// File: doc/BRIEF.md
# NAND Flash Pin-Level Host Interface

This block sits between a simple register bus and a raw NAND flash device whose pins are driven by software. A control register holds the chip-enable, command-latch, address-latch and write-protect levels, and its readback merges in the flash's live ready/busy line. A data register moves bytes to and from the flash, pulsing a write or read strobe for each byte.

Every byte that crosses the data register, in either direction, is folded into an ECC accumulator. The accumulator keeps a 6-bit column parity, two 8-bit line-parity bytes and a byte counter. Software reads the parity bytes back bit-interleaved through two registers and clears the accumulator with a write to a dedicated clear offset. Each bus request receives one acknowledge. A 32-bit data read takes two flash bytes and is acknowledged one cycle later than every other access.

Top module: `nand_pin_ctrl`

## Requirements
- R1: After reset the control register is 0, so nand_ce, nand_cle, nand_ale and nand_wp are low. The ECC counter, column parity and both line-parity bytes are 0.
- R2: The control register is at offset 0x18. Bit 1 drives nand_cle, bit 2 drives nand_ale and bit 3 drives nand_wp. nand_ce is high when bit 0 or bit 4 is set.
- R3: A control write stores wdata[7:0] with bit 5 cleared. A control read returns the stored byte in bits 7:0, with bit 5 set exactly when nand_rdy is high. All upper bits read as 0.
- R4: A write to the data offset 0x14, of either size, pulses nand_we for one cycle with wdata[7:0] on nand_dq_out.
- R5: A byte-size read of 0x14 pulses nand_re once. It returns the flash byte in bits 7:0, with all other bits 0.
- R6: A word-size read of 0x14 pulses nand_re in two consecutive cycles. It returns the first byte in bits 7:0 and the second in bits 23:16, with all other bits 0.
- R7: The ECC counter increments once for every byte written or read through 0x14. Offset 0x0C returns its low 8 bits.
- R8: Each digested byte b is XORed into the column parity at offset 0x08. Its bits are: bit0 = ^b{0,2,4,6}, bit1 = ^b{1,3,5,7}, bit2 = ^b{0,1,4,5}, bit3 = ^b{2,3,6,7}, bit4 = ^b[3:0] and bit5 = ^b[7:4].
- R9: When a digested byte has odd parity, line byte 1 is XORed with the counter's low 8 bits taken before the increment, and line byte 0 with their complement. Offset 0x00 returns line0[4+k] on bit 2k and line1[4+k] on bit 2k+1, for k = 0..3.
- R10: Offset 0x04 returns line0[k] on bit 2k and line1[k] on bit 2k+1, for k = 0..3.
- R11: Any write to 0x10 zeroes the counter and all parity state, whatever the data. The control register is left as it was.
- R12: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x14 and 0x18 return 0. Writes to offsets other than 0x10, 0x14 and 0x18 change nothing.
- R13: bus_ack rises one cycle after a request, except for a word-size data read, which is acknowledged two cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Request strobe, one cycle, only while no access is in flight |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | AW (6) | Byte offset within the register window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete |
| nand_dq_in | input | 8 | Byte presented by the flash |
| nand_rdy | input | 1 | Flash ready (1) or busy (0) |
| nand_dq_out | output | 8 | Byte driven to the flash |
| nand_we | output | 1 | Write strobe, one cycle per byte |
| nand_re | output | 1 | Read strobe, one cycle per byte; the flash advances after the strobed edge |
| nand_ce | output | 1 | Chip enable, active high |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp | output | 1 | Write-protect level |

## Verification
The assertions assume that bus_req is raised only when no word read is in its second cycle. They also assume that a flash byte is stable from the strobe cycle up to the edge that samples it. The directed stimulus keeps to both assumptions: it raises a request only after the previous acknowledge has been seen, and its flash stub changes its byte only on an edge where nand_re is high. The expected ECC values come from a separate per-byte model built from the column-group and line-parity definitions. The digested bytes are chosen to include both parities and to cross several counter values.

// File: rtl/nand_pin_ctrl.sv
module nand_pin_ctrl #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int CNT_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic          bus_word,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  input  logic [7:0]    nand_dq_in,
  input  logic          nand_rdy,
  output logic [7:0]    nand_dq_out,
  output logic          nand_we,
  output logic          nand_re,
  output logic          nand_ce,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_wp
);
  localparam logic [AW-1:0] A_LPLO = AW'(6'h00);
  localparam logic [AW-1:0] A_LPHI = AW'(6'h04);
  localparam logic [AW-1:0] A_COL  = AW'(6'h08);
  localparam logic [AW-1:0] A_CNT  = AW'(6'h0C);
  localparam logic [AW-1:0] A_CLR  = AW'(6'h10);
  localparam logic [AW-1:0] A_IO   = AW'(6'h14);
  localparam logic [AW-1:0] A_CTL  = AW'(6'h18);

  logic [7:0]       ctl, lp0, lp1, first_b;
  logic [5:0]       cp;
  logic [CNT_W-1:0] cnt;
  logic             second;
  logic [7:0]       lp_lo, lp_hi, dig;

  wire start  = bus_req && !second;
  wire hit_io = bus_addr == A_IO;
  wire rd_io  = start && !bus_we && hit_io;
  wire clr    = start && bus_we && bus_addr == A_CLR;
  wire ctl_wr = start && bus_we && bus_addr == A_CTL;

  assign nand_we     = start && bus_we && hit_io;
  assign nand_re     = rd_io || second;
  assign nand_dq_out = bus_wdata[7:0];
  assign nand_ce     = ctl[0] | ctl[4];
  assign nand_cle    = ctl[1];
  assign nand_ale    = ctl[2];
  assign nand_wp     = ctl[3];
  assign dig         = nand_we ? bus_wdata[7:0] : nand_dq_in;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      lp_lo[2*k]   = lp0[4+k];
      lp_lo[2*k+1] = lp1[4+k];
      lp_hi[2*k]   = lp0[k];
      lp_hi[2*k+1] = lp1[k];
    end
  end

  function automatic logic [5:0] col_of(input logic [7:0] b);
    return {^b[7:4], ^b[3:0], ^{b[7:6], b[3:2]}, ^{b[5:4], b[1:0]},
            ^{b[7], b[5], b[3], b[1]}, ^{b[6], b[4], b[2], b[0]}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; cp <= '0; lp0 <= '0; lp1 <= '0; cnt <= '0;
      second <= 1'b0; first_b <= '0; bus_ack <= 1'b0; bus_rdata <= '0;
    end else begin
      if (ctl_wr) ctl <= bus_wdata[7:0] & 8'hDF;
      if (clr) begin
        cp <= '0; lp0 <= '0; lp1 <= '0; cnt <= '0;
      end else if (nand_re || nand_we) begin
        cp  <= cp ^ col_of(dig);
        cnt <= cnt + 1'b1;
        if (^dig) begin
          lp0 <= lp0 ^ ~cnt[7:0];
          lp1 <= lp1 ^ cnt[7:0];
        end
      end
      second  <= rd_io && bus_word;
      if (rd_io) first_b <= nand_dq_in;
      bus_ack <= (start && !(rd_io && bus_word)) || second;
      if (second)
        bus_rdata <= DW'({8'h00, nand_dq_in, 8'h00, first_b});
      else if (start && !bus_we) begin
        case (bus_addr)
          A_LPLO:  bus_rdata <= DW'(lp_lo);
          A_LPHI:  bus_rdata <= DW'(lp_hi);
          A_COL:   bus_rdata <= DW'(cp);
          A_CNT:   bus_rdata <= DW'(cnt[7:0]);
          A_IO:    bus_rdata <= DW'(nand_dq_in);
          A_CTL:   bus_rdata <= DW'(ctl | {2'b00, nand_rdy, 5'b0});
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R4 R5 R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_re && nand_we));
  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_re || nand_we) |=> cnt == $past(cnt) + 1'b1);
  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && cp == '0 && lp0 == '0 && lp1 == '0));
  // R13
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(rd_io && bus_word)) |=> bus_ack);
  // R6
  word_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second |=> (bus_ack && !second));
  // R3
  ctl_busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ctl[5]);
endmodule

// File: tb/tb_nand_pin_ctrl.sv
`timescale 1ns/1ps
module tb_nand_pin_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_word = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, nand_rdy = 0;
  logic [7:0] nand_dq_in, nand_dq_out;
  logic nand_we, nand_re, nand_ce, nand_cle, nand_ale, nand_wp;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [7:0] idx = 0, last_wr = 0;
  logic [5:0] m_cp = 0;
  logic [7:0] m_l0 = 0, m_l1 = 0, m_cnt = 0;

  always #4 clk = ~clk;

  nand_pin_ctrl dut (.*);

  function automatic logic [7:0] stub_byte(input logic [7:0] i);
    return i * 8'd37 + 8'd5;
  endfunction
  assign nand_dq_in = stub_byte(idx);

  always @(posedge clk) begin
    if (nand_re) begin idx <= idx + 1; rd_cnt <= rd_cnt + 1; end
    if (nand_we) begin last_wr <= nand_dq_out; wr_cnt <= wr_cnt + 1; end
  end

  task automatic model(input logic [7:0] b);
    logic [5:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) if (b[i]) begin
      c[i % 2] ^= 1'b1;
      c[2 + ((i / 2) % 2)] ^= 1'b1;
      c[4 + i / 4] ^= 1'b1;
    end
    m_cp ^= c;
    if (^b) begin m_l0 ^= ~m_cnt; m_l1 ^= m_cnt; end
    m_cnt++;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic [5:0] a, input logic we, input logic word,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_req = 1; bus_addr = a; bus_we = we; bus_word = word; bus_wdata = wd;
    @(negedge clk);
    bus_req = 0;
    cyc = 1;
    while (!bus_ack && cyc < 10) begin @(negedge clk); cyc++; end
    rd = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] d; int c;
    chk("R1 pins", {nand_ce, nand_cle, nand_ale, nand_wp}, 0);
    acc(6'h18, 0, 1, 0, d, c); chk("R1 ctl", d, 0);
    acc(6'h0C, 0, 1, 0, d, c); chk("R1 cnt", d, 0);
    acc(6'h08, 0, 1, 0, d, c); chk("R1 col", d, 0);
    acc(6'h00, 0, 1, 0, d, c); chk("R1 lplo", d, 0);
  endtask

  task automatic test_ctl();
    logic [31:0] d; int c;
    acc(6'h18, 1, 1, 32'hFFFF_FFFF, d, c);
    chk("R13 ctl write ack", c, 1);
    chk("R2 all pins", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'hF);
    nand_rdy = 0; acc(6'h18, 0, 1, 0, d, c); chk("R3 busy read", d, 32'hDF);
    nand_rdy = 1; acc(6'h18, 0, 1, 0, d, c); chk("R3 ready read", d, 32'hFF);
    acc(6'h18, 1, 0, 32'h10, d, c);
    chk("R2 ce1 only", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'h8);
    acc(6'h18, 1, 0, 32'h06, d, c);
    chk("R2 cle ale", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'h6);
    acc(6'h18, 1, 0, 32'h01, d, c);
    chk("R2 ce0 only", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'h8);
  endtask

  task automatic test_data();
    logic [31:0] d; int c, w0, r0; logic [7:0] b0, b1;
    w0 = wr_cnt;
    acc(6'h14, 1, 1, 32'hABCD_EF12, d, c); model(8'h12);
    chk("R4 byte out", last_wr, 8'h12); chk("R4 one strobe", wr_cnt - w0, 1);
    chk("R13 write ack", c, 1);
    for (int i = 0; i < 20; i++) begin
      acc(6'h14, 1, 0, 32'(i * 53 + 7), d, c); model(8'(i * 53 + 7));
    end
    r0 = rd_cnt; b0 = stub_byte(idx);
    acc(6'h14, 0, 0, 0, d, c); model(b0);
    chk("R5 byte read", d, {24'h0, b0}); chk("R5 one strobe", rd_cnt - r0, 1);
    chk("R13 byte read ack", c, 1);
    r0 = rd_cnt; b0 = stub_byte(idx); b1 = stub_byte(idx + 1);
    acc(6'h14, 0, 1, 0, d, c); model(b0); model(b1);
    chk("R6 word read", d, {8'h0, b1, 8'h0, b0}); chk("R6 two strobes", rd_cnt - r0, 2);
    chk("R13 word ack", c, 2);
    for (int i = 0; i < 5; i++) begin
      b0 = stub_byte(idx); b1 = stub_byte(idx + 1);
      acc(6'h14, 0, 1, 0, d, c); model(b0); model(b1);
    end
  endtask

  task automatic test_ecc();
    logic [31:0] d; int c; logic [7:0] lo, hi;
    for (int k = 0; k < 4; k++) begin
      lo[2*k] = m_l0[4+k]; lo[2*k+1] = m_l1[4+k];
      hi[2*k] = m_l0[k];   hi[2*k+1] = m_l1[k];
    end
    acc(6'h0C, 0, 1, 0, d, c); chk("R7 counter", d, {24'h0, m_cnt});
    acc(6'h08, 0, 1, 0, d, c); chk("R8 column", d, {26'h0, m_cp});
    acc(6'h00, 0, 1, 0, d, c); chk("R9 line low", d, {24'h0, lo});
    acc(6'h04, 0, 1, 0, d, c); chk("R10 line high", d, {24'h0, hi});
  endtask

  task automatic test_clear();
    logic [31:0] d; int c;
    acc(6'h10, 1, 1, 32'hFFFF_FFFF, d, c);
    m_cp = 0; m_l0 = 0; m_l1 = 0; m_cnt = 0;
    acc(6'h0C, 0, 1, 0, d, c); chk("R11 counter", d, 0);
    acc(6'h08, 0, 1, 0, d, c); chk("R11 column", d, 0);
    acc(6'h00, 0, 1, 0, d, c); chk("R11 line low", d, 0);
    acc(6'h04, 0, 1, 0, d, c); chk("R11 line high", d, 0);
    acc(6'h18, 0, 1, 0, d, c); chk("R11 ctl kept", d, 32'h21);
    acc(6'h14, 1, 0, 32'h0000_0003, d, c); model(8'h03);
    acc(6'h14, 1, 0, 32'h0000_0001, d, c); model(8'h01);
    test_ecc();
  endtask

  task automatic test_undef();
    logic [31:0] d; int c, w0;
    w0 = wr_cnt;
    acc(6'h1C, 1, 1, 32'h0000_0000, d, c);
    acc(6'h3C, 1, 1, 32'h0000_00FF, d, c);
    acc(6'h08, 1, 1, 32'h0000_003F, d, c);
    chk("R12 pins", {nand_ce, nand_cle, nand_ale, nand_wp}, 4'h8);
    chk("R12 no flash write", wr_cnt - w0, 0);
    acc(6'h18, 0, 1, 0, d, c); chk("R12 ctl", d, 32'h21);
    acc(6'h1C, 0, 1, 0, d, c); chk("R12 read 1C", d, 0);
    acc(6'h10, 0, 1, 0, d, c); chk("R12 read 10", d, 0);
    test_ecc();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_ctl();
    test_data();
    test_ecc();
    test_clear();
    test_undef();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule